// File: doc/BRIEF.md
# Multi-Bus Address Latch Bridge

This block carries the address of whichever agent currently owns the bus between three address buses. The host bus and the system bus are both 30 bits wide and carry address bits 31:2. On the system bus the top byte (bits 31:24) is active-low. The peripheral bus is narrower and carries bits 19:2. Each bus appears as an input port, an output port and a drive-enable, so the block never models pads.

At the start of every bus cycle an address strobe samples a master-type code. The code selects one of five agents: host CPU, 32-bit system master, 16-bit legacy master, DMA or refresh. From the sampled code, and from how many clocks have passed since the strobe, the block produces three latch enables and four output enables. These drive internal models of three latching transceivers:

- a host-side latch feeding the system bus;
- a system-side latch feeding the host bus;
- a peripheral latch that sits between the system bus and the peripheral bus.

A latch enable is either pulsed for one clock, which captures and then holds the address, or held high for the whole cycle, which makes the latch transparent. The memory/IO qualifier is forwarded in the same direction as the address. A cycle-end strobe returns the block to idle.

Top module: `abx_bridge`

## Requirements
- R1: After reset, and from the first clock after a cycle-end strobe, every output enable, every latch enable, every drive-enable, every address output and both qualifier outputs are 0.
- R2: Master codes are 0 CPU, 1 system, 2 legacy, 3 DMA, 4 refresh. Output enables while busy:
  - CPU, DMA and refresh enable host-to-system and system-to-peripheral only.
  - System enables system-to-host and system-to-peripheral only.
  - Legacy enables system-to-host and peripheral-to-system only.
  - Codes 5 to 7 enable nothing.
- R3: The system-side latch enable is high for the whole busy cycle for all five masters. The host-side latch enable is high only in the first busy clock for CPU, high for the whole cycle for DMA and refresh, and low for system and legacy.
- R4: The peripheral latch enable is high for the whole cycle for a legacy master. For CPU, system, DMA and refresh masters it is high only in the first busy clock.
- R5: A pulsed enable is high in exactly the one clock that follows the edge that sampled the strobe, and low in the next clock.
- R6: With host-to-system enabled, the system address output equals the host address with bits 31:24 (vector bits 29:22) inverted. Both system drive-enables are set, and the peripheral output equals host bits 19:2.
- R7: With a system master, the host address output equals the system address with bits 31:24 inverted, and the peripheral output equals system bits 19:2.
- R8: With a legacy master:
  - only system bits 16:2 (vector 14:0) are driven, and they come from peripheral bits 16:2;
  - the upper system drive-enable stays low;
  - the host output is {inverted system bits 31:24, system bits 23:17, peripheral bits 16:2}, so a pulled-up all-ones upper byte reads as zeros on the host bus.
- R9: Once a pulsed latch has closed, it keeps the captured address. Changes on its source bus do not reach its output for the rest of the cycle.
- R10: The system qualifier output equals the host qualifier input for CPU, DMA and refresh masters. The host qualifier output equals the system qualifier input for system and legacy masters.
- R11: The master code is used only at the strobe. Changing it later in the cycle has no effect on any enable or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | Address strobe; samples the master code |
| cyc_end | input | 1 | Ends the bus cycle (the strobe wins if both are set) |
| master | input | 3 | Master-type code |
| host_addr_in | input | 30 | Host bus address bits 31:2 as seen on the bus |
| host_mio_in | input | 1 | Host memory/IO qualifier |
| host_addr_out | output | 30 | Address driven onto the host bus |
| host_mio_out | output | 1 | Qualifier driven onto the host bus |
| host_drive | output | 1 | Host bus drive-enable |
| sys_addr_in | input | 30 | System bus address bits 31:2, top byte active-low |
| sys_mio_in | input | 1 | System memory/IO qualifier |
| sys_addr_out | output | 30 | Address driven onto the system bus |
| sys_mio_out | output | 1 | Qualifier driven onto the system bus |
| sys_drive_hi | output | 1 | Drive-enable for system bits 31:17 |
| sys_drive_lo | output | 1 | Drive-enable for system bits 16:2 |
| leg_addr_in | input | 18 | Peripheral bus address bits 19:2 |
| leg_addr_out | output | 18 | Address driven onto the peripheral bus |
| leg_drive | output | 1 | Peripheral bus drive-enable |
| oe_h2s | output | 1 | Host-to-system output enable |
| oe_s2h | output | 1 | System-to-host output enable |
| oe_s2l | output | 1 | System-to-peripheral output enable |
| oe_l2s | output | 1 | Peripheral-to-system output enable |
| le_host | output | 1 | Host-side latch enable |
| le_sys | output | 1 | System-side latch enable |
| le_leg | output | 1 | Peripheral latch enable |

## Verification
The bench builds the bridge with its defaults:

- 30-bit host and system buses;
- an 8-bit inverted top field;
- an 18-bit peripheral bus;
- a 15-bit peripheral-to-system pass field.

Under these values the inversion boundary (vector bit 22), the pass boundary (bit 15) and the top of the peripheral field (bit 17) all differ. Random addresses can therefore show that bits 17:15 reach the peripheral bus but never cross back, and that the inversion stops exactly at bit 22. Each cycle is checked in three phases: the pulse clock, a hold clock with fresh source addresses and a changed master code, and idle.

// File: rtl/abx_pkg.sv
// Package: shared types for the address latch bridge.
// Assumes the master code is 3 bits wide; codes above 4 are unused.
package abx_pkg;

    typedef enum logic [2:0] {
        MST_CPU  = 3'd0,
        MST_SYS  = 3'd1,
        MST_LEG  = 3'd2,
        MST_DMA  = 3'd3,
        MST_RFSH = 3'd4
    } mst_e;

    // Control word that drives the three transceiver models.
    typedef struct packed {
        logic hs_oe;   // host latch -> system bus
        logic sh_oe;   // system latch -> host bus
        logic sl_oe;   // peripheral latch -> peripheral bus
        logic ls_oe;   // peripheral latch -> system bus, low field only
        logic h_le;    // host-side latch enable
        logic s_le;    // system-side latch enable
        logic l_le;    // peripheral latch enable
    } ctl_s;

endpackage

// File: rtl/abx_seq.sv
// Module: abx_seq
// Tracks the bus cycle. Samples the master code on the strobe, keeps a busy
// flag until the end strobe, and raises a one-clock pulse after each strobe.
// Assumes the strobe wins over the end strobe in the same clock.
module abx_seq
    import abx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_start,
    input  logic       cyc_end,
    input  logic [2:0] master,
    output logic       busy,
    output logic       pulse,
    output mst_e       mst_q
);

    // Cycle state: busy flag, first-clock pulse and the captured master.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            pulse <= 1'b0;
            mst_q <= MST_CPU;
        end else if (cyc_start) begin
            busy  <= 1'b1;
            pulse <= 1'b1;
            mst_q <= mst_e'(master);
        end else begin
            pulse <= 1'b0;
            if (cyc_end) begin
                busy <= 1'b0;
            end
        end
    end

    AST_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse && !cyc_start |=> !pulse);                                   // R5
    AST_PULSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> busy);                                                   // R5
    AST_MST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_start |=> $stable(mst_q));                                    // R11

endmodule

// File: rtl/abx_dec.sv
// Module: abx_dec
// Turns the captured master type and the cycle phase into latch and output
// enables. Assumes busy and pulse come from abx_seq; everything is off
// while idle.
module abx_dec
    import abx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic pulse,
    input  mst_e mst,
    output ctl_s ctl
);

    // Per-master enable pattern; pulsed enables follow the first-clock pulse.
    always_comb begin
        ctl = '0;
        if (busy) begin
            case (mst)
                MST_CPU: begin
                    ctl.hs_oe = 1'b1;
                    ctl.sl_oe = 1'b1;
                    ctl.h_le  = pulse;
                    ctl.s_le  = 1'b1;
                    ctl.l_le  = pulse;
                end
                MST_DMA, MST_RFSH: begin
                    ctl.hs_oe = 1'b1;
                    ctl.sl_oe = 1'b1;
                    ctl.h_le  = 1'b1;
                    ctl.s_le  = 1'b1;
                    ctl.l_le  = pulse;
                end
                MST_SYS: begin
                    ctl.sh_oe = 1'b1;
                    ctl.sl_oe = 1'b1;
                    ctl.s_le  = 1'b1;
                    ctl.l_le  = pulse;
                end
                MST_LEG: begin
                    ctl.sh_oe = 1'b1;
                    ctl.ls_oe = 1'b1;
                    ctl.s_le  = 1'b1;
                    ctl.l_le  = 1'b1;
                end
                default: ctl = '0;
            endcase
        end
    end

    AST_NO_HOST_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.hs_oe && ctl.sh_oe));                                        // R2
    AST_NO_LEG_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.sl_oe && ctl.ls_oe));                                        // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ctl == '0));                                            // R1
    AST_SYS_LE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.hs_oe || ctl.sh_oe) |-> ctl.s_le);                            // R3

endmodule

// File: rtl/abx_latch.sv
// Module: abx_latch
// Clocked model of a latching transceiver. While le is high the output
// follows din (transparent). At each edge with le high the value is stored,
// and while le is low the stored value is shown.
module abx_latch #(
    parameter int W = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] held_q;

    // Capture storage: follows din at every edge while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (le) begin
            held_q <= din;
        end
    end

    // Output: transparent while enabled, stored value otherwise.
    always_comb begin
        dout = le ? din : held_q;
    end

    AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !le |=> (le || $stable(dout)));                                    // R9

endmodule

// File: rtl/abx_bridge.sv
// Module: abx_bridge (top)
// Address bridge between host, system and peripheral buses. It sequences
// the cycle, decodes the enables and models three latching transceivers.
// The top IW bits are inverted on every host/system crossing. Outputs are
// forced to zero whenever they are not driven.
module abx_bridge
    import abx_pkg::*;
#(
    parameter int AW = 30,   // host/system address width (bits 31:2)
    parameter int LW = 18,   // peripheral address width (bits 19:2)
    parameter int PW = 15,   // peripheral-to-system pass field (bits 16:2)
    parameter int IW = 8     // active-low upper field on the system bus
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_start,
    input  logic          cyc_end,
    input  logic [2:0]    master,
    input  logic [AW-1:0] host_addr_in,
    input  logic          host_mio_in,
    output logic [AW-1:0] host_addr_out,
    output logic          host_mio_out,
    output logic          host_drive,
    input  logic [AW-1:0] sys_addr_in,
    input  logic          sys_mio_in,
    output logic [AW-1:0] sys_addr_out,
    output logic          sys_mio_out,
    output logic          sys_drive_hi,
    output logic          sys_drive_lo,
    input  logic [LW-1:0] leg_addr_in,
    output logic [LW-1:0] leg_addr_out,
    output logic          leg_drive,
    output logic          oe_h2s,
    output logic          oe_s2h,
    output logic          oe_s2l,
    output logic          oe_l2s,
    output logic          le_host,
    output logic          le_sys,
    output logic          le_leg
);

    localparam int INV_LO = AW - IW;

    logic          busy;
    logic          pulse;
    mst_e          mst_q;
    ctl_s          ctl;
    logic [AW-1:0] h_q, h2s, s_q, s2h, s_din;
    logic [LW-1:0] l_din, l_q;

    abx_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .cyc_end   (cyc_end),
        .master    (master),
        .busy      (busy),
        .pulse     (pulse),
        .mst_q     (mst_q)
    );

    abx_dec u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (busy),
        .pulse (pulse),
        .mst   (mst_q),
        .ctl   (ctl)
    );

    // Host-side latch: captures the host bus for the system direction.
    abx_latch #(.W(AW)) u_hlat (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (ctl.h_le),
        .din   (host_addr_in),
        .dout  (h_q)
    );

    // Upper-field inversion in both crossing directions.
    for (genvar i = 0; i < AW; i++) begin : g_flip
        if (i >= INV_LO) begin : g_inv
            assign h2s[i] = ~h_q[i];
            assign s2h[i] = ~s_q[i];
        end else begin : g_pass
            assign h2s[i] = h_q[i];
            assign s2h[i] = s_q[i];
        end
    end

    // Peripheral latch source: the peripheral bus for a legacy master,
    // otherwise the system bus as it is currently driven.
    always_comb begin
        if (mst_q == MST_LEG) begin
            l_din = leg_addr_in;
        end else if (ctl.hs_oe) begin
            l_din = h2s[LW-1:0];
        end else begin
            l_din = sys_addr_in[LW-1:0];
        end
    end

    abx_latch #(.W(LW)) u_llat (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (ctl.l_le),
        .din   (l_din),
        .dout  (l_q)
    );

    // System-side latch source: the low field comes from this block when it
    // drives that field itself.
    always_comb begin
        if (ctl.ls_oe) begin
            s_din = {sys_addr_in[AW-1:PW], l_q[PW-1:0]};
        end else begin
            s_din = sys_addr_in;
        end
    end

    abx_latch #(.W(AW)) u_slat (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (ctl.s_le),
        .din   (s_din),
        .dout  (s_q)
    );

    // Bus outputs, gated to zero when not driven.
    always_comb begin
        host_addr_out = ctl.sh_oe ? s2h : '0;
        host_mio_out  = ctl.sh_oe & sys_mio_in;
        host_drive    = ctl.sh_oe;

        sys_addr_out[AW-1:PW] = ctl.hs_oe ? h2s[AW-1:PW] : '0;
        if (ctl.hs_oe) begin
            sys_addr_out[PW-1:0] = h2s[PW-1:0];
        end else if (ctl.ls_oe) begin
            sys_addr_out[PW-1:0] = l_q[PW-1:0];
        end else begin
            sys_addr_out[PW-1:0] = '0;
        end
        sys_mio_out  = ctl.hs_oe & host_mio_in;
        sys_drive_hi = ctl.hs_oe;
        sys_drive_lo = ctl.hs_oe | ctl.ls_oe;

        leg_addr_out = ctl.sl_oe ? l_q : '0;
        leg_drive    = ctl.sl_oe;
    end

    // Control lines brought out for observation.
    always_comb begin
        oe_h2s  = ctl.hs_oe;
        oe_s2h  = ctl.sh_oe;
        oe_s2l  = ctl.sl_oe;
        oe_l2s  = ctl.ls_oe;
        le_host = ctl.h_le;
        le_sys  = ctl.s_le;
        le_leg  = ctl.l_le;
    end

    AST_H2S_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_h2s && le_host) |->
            (sys_addr_out[AW-1:INV_LO] == ~host_addr_in[AW-1:INV_LO]));    // R6
    AST_LEG_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        oe_l2s |-> (!sys_drive_hi && sys_drive_lo));                       // R8
    AST_S2H_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_s2h && !oe_l2s) |->
            (host_addr_out[AW-1:INV_LO] == ~sys_addr_in[AW-1:INV_LO]));    // R7
    AST_MIO_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_drive && sys_drive_hi));                                    // R10

endmodule

// File: tb/tb_abx_bridge.sv
`timescale 1ns/1ps
module tb_abx_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_start = 1'b0;
    logic        cyc_end = 1'b0;
    logic [2:0]  master = 3'd0;
    logic [29:0] host_addr_in = '0;
    logic        host_mio_in = 1'b0;
    logic [29:0] host_addr_out;
    logic        host_mio_out;
    logic        host_drive;
    logic [29:0] sys_addr_in = '0;
    logic        sys_mio_in = 1'b0;
    logic [29:0] sys_addr_out;
    logic        sys_mio_out;
    logic        sys_drive_hi;
    logic        sys_drive_lo;
    logic [17:0] leg_addr_in = '0;
    logic [17:0] leg_addr_out;
    logic        leg_drive;
    logic        oe_h2s, oe_s2h, oe_s2l, oe_l2s, le_host, le_sys, le_leg;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    abx_bridge dut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_end(cyc_end),
        .master(master),
        .host_addr_in(host_addr_in), .host_mio_in(host_mio_in),
        .host_addr_out(host_addr_out), .host_mio_out(host_mio_out),
        .host_drive(host_drive),
        .sys_addr_in(sys_addr_in), .sys_mio_in(sys_mio_in),
        .sys_addr_out(sys_addr_out), .sys_mio_out(sys_mio_out),
        .sys_drive_hi(sys_drive_hi), .sys_drive_lo(sys_drive_lo),
        .leg_addr_in(leg_addr_in), .leg_addr_out(leg_addr_out),
        .leg_drive(leg_drive),
        .oe_h2s(oe_h2s), .oe_s2h(oe_s2h), .oe_s2l(oe_s2l), .oe_l2s(oe_l2s),
        .le_host(le_host), .le_sys(le_sys), .le_leg(le_leg)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [29:0] flip(input logic [29:0] x);
        return {~x[29:22], x[21:0]};
    endfunction

    // Expected enables {h2s, s2h, s2l, l2s, le_host, le_sys, le_leg};
    // phase 1 = first busy clock, 2 = later busy clock.
    function automatic logic [6:0] exp_ctl(input logic [2:0] m, input int ph);
        logic p;
        p = (ph == 1);
        case (m)
            3'd0:       return {4'b1010, p,    1'b1, p};
            3'd3, 3'd4: return {4'b1010, 1'b1, 1'b1, p};
            3'd1:       return {4'b0110, 1'b0, 1'b1, p};
            3'd2:       return {4'b0101, 1'b0, 1'b1, 1'b1};
            default:    return 7'd0;
        endcase
    endfunction

    function automatic logic [6:0] act_ctl();
        return {oe_h2s, oe_s2h, oe_s2l, oe_l2s, le_host, le_sys, le_leg};
    endfunction

    task automatic chk_idle(input string tag);
        chk("R1", {tag, " enables"}, {25'd0, act_ctl()}, 32'd0);
        chk("R1", {tag, " host out"}, {1'b0, host_drive, host_addr_out}, 32'd0);
        chk("R1", {tag, " sys out"},
            {sys_drive_hi, sys_drive_lo, sys_addr_out}, 32'd0);
        chk("R1", {tag, " leg out"}, {13'd0, leg_drive, leg_addr_out}, 32'd0);
        chk("R1", {tag, " mio"}, {30'd0, host_mio_out, sys_mio_out}, 32'd0);
    endtask

    // Check the address outputs for master m against the current inputs
    // (h, s, l) and the values captured in the pulse clock (h0, s0).
    task automatic chk_data(input logic [2:0] m, input int ph,
                            input logic [29:0] h, input logic [29:0] s,
                            input logic [17:0] l, input logic [29:0] h0,
                            input logic [29:0] s0, input logic hm,
                            input logic sm);
        logic [29:0] eh, es;
        logic [17:0] el;
        logic [3:0]  ed;
        logic        ehm, esm;
        string       rq;
        eh = '0; es = '0; el = '0; ed = '0; ehm = 1'b0; esm = 1'b0;
        rq = (ph == 2) ? "R9" : "R6";
        case (m)
            3'd0: begin
                es = flip(h0); el = h0[17:0]; ed = 4'b0111; esm = hm;
            end
            3'd3, 3'd4: begin
                es = flip(h); el = h0[17:0]; ed = 4'b0111; esm = hm;
            end
            3'd1: begin
                eh = flip(s); el = s0[17:0]; ed = 4'b1001; ehm = sm;
                rq = (ph == 2) ? "R9" : "R7";
            end
            3'd2: begin
                eh = flip({s[29:15], l[14:0]}); es = {15'd0, l[14:0]};
                ed = 4'b1010; ehm = sm; rq = "R8";
            end
            default: ;
        endcase
        chk(rq, "sys addr out", {2'b0, sys_addr_out}, {2'b0, es});
        chk(rq, "host addr out", {2'b0, host_addr_out}, {2'b0, eh});
        chk(rq, "leg addr out", {14'd0, leg_addr_out}, {14'd0, el});
        chk(rq, "drives {host,hi,lo,leg}",
            {28'd0, host_drive, sys_drive_hi, sys_drive_lo, leg_drive},
            {28'd0, ed});
        chk("R10", "mio {host,sys}", {30'd0, host_mio_out, sys_mio_out},
            {30'd0, ehm, esm});
    endtask

    // One full bus cycle: strobe, first clock, hold clock with new inputs
    // and a different master code, then cycle end and idle.
    task automatic run_cycle(input logic [2:0] m, input logic [2:0] m2,
                             input logic [29:0] h, input logic [29:0] s,
                             input logic [17:0] l, input logic [29:0] h2,
                             input logic [29:0] s2, input logic [17:0] l2,
                             input logic hm, input logic sm);
        logic [6:0] ec;
        @(negedge clk);
        master = m; host_addr_in = h; sys_addr_in = s; leg_addr_in = l;
        host_mio_in = hm; sys_mio_in = sm; cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        #1;
        ec = exp_ctl(m, 1);
        chk("R2", "output enables", {28'd0, act_ctl()[6:3]}, {28'd0, ec[6:3]});
        chk("R3", "host/sys latch enables", {30'd0, le_host, le_sys},
            {30'd0, ec[2:1]});
        chk("R4", "leg latch enable", {31'd0, le_leg}, {31'd0, ec[0]});
        chk_data(m, 1, h, s, l, h, s, hm, sm);
        @(negedge clk);
        host_addr_in = h2; sys_addr_in = s2; leg_addr_in = l2; master = m2;
        #1;
        ec = exp_ctl(m, 2);
        chk("R5", "enables after pulse", {25'd0, act_ctl()}, {25'd0, ec});
        chk("R11", "code change ignored", {28'd0, act_ctl()[6:3]},
            {28'd0, ec[6:3]});
        chk_data(m, 2, h2, s2, l2, h, s, hm, sm);
        @(negedge clk);
        cyc_end = 1'b1;
        @(negedge clk);
        cyc_end = 1'b0;
        #1;
        chk_idle("after end");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [29:0] h, s, h2, s2;
        logic [17:0] l, l2;
        logic [2:0]  m, m2;
        int unsigned seed;
        seed = $urandom(32'h5EED_0A1B);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk_idle("reset");

        // Directed: each master type once.
        run_cycle(3'd0, 3'd1, 30'h2A5A_1234, 30'h0, 18'h0,
                  30'h1111_1111, 30'h0, 18'h0, 1'b1, 1'b0);
        run_cycle(3'd1, 3'd2, 30'h0, 30'h3C00_BEEF, 18'h0,
                  30'h0, 30'h0F0F_0F0F, 18'h0, 1'b0, 1'b1);
        // Legacy: pulled-up upper byte must reach host as zeros (R8).
        run_cycle(3'd2, 3'd0, 30'h0, 30'h3FC0_0000 | 30'h0015_8000,
                  18'h2_ABCD, 30'h0, 30'h3FC0_0000, 18'h1_7FFF, 1'b0, 1'b1);
        run_cycle(3'd3, 3'd2, 30'h0123_4567, 30'h0, 18'h0,
                  30'h3FFF_FFFF, 30'h0, 18'h0, 1'b1, 1'b0);
        run_cycle(3'd4, 3'd1, 30'h3000_00FF, 30'h0, 18'h0,
                  30'h0000_0000, 30'h0, 18'h0, 1'b1, 1'b1);
        // Unused code enables nothing (R2).
        run_cycle(3'd6, 3'd0, 30'h3FFF_FFFF, 30'h3FFF_FFFF, 18'h3_FFFF,
                  30'h1, 30'h1, 18'h1, 1'b1, 1'b1);

        // Constrained random cycles.
        for (int k = 0; k < 40; k++) begin
            m  = 3'($urandom % 5);
            m2 = 3'($urandom % 8);
            h  = 30'($urandom); s  = 30'($urandom); l  = 18'($urandom);
            h2 = 30'($urandom); s2 = 30'($urandom); l2 = 18'($urandom);
            if (m == 3'd2) begin
                s[29:22]  = 8'hFF;
                s2[29:22] = 8'hFF;
            end
            run_cycle(m, m2, h, s, l, h2, s2, l2,
                      1'($urandom), 1'($urandom));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule